// File: doc/BRIEF.md
# Parallel Port Controller With Bit-Set/Reset

This block is a programmable parallel I/O controller with three 8-bit ports (A, B and C) behind a small synchronous CPU bus. The bus has an active-low chip select, active-low read and write strobes and a 2-bit address. Three of the addresses reach the data ports. The fourth address reaches a write-only control port.

A byte written to the control port does one of two jobs, chosen by its top bit. When the top bit is set, the byte is a configuration word. It sets the direction of port A, port B and each half of port C, and it stores the mode numbers of the two port groups. When the top bit is clear, the byte is a single-bit command: it sets or clears one chosen bit of the port C output latch and leaves every other bit alone, so software never needs a read-modify-write.

Each port drives its pins through an output value and a per-bit output enable. The enable is high only where the port, or half of port C, is configured as an output. Only the basic latched-output and pin-input behaviour is active. The handshake and bidirectional group modes are decoded and held on status outputs, but they do not change how the ports behave.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset, every output enable is 0, every output latch is 0x00, `grpa_mode` is 0, `grpb_mode` is 0 and `rdata` is 0x00.
- R2: A write happens at a rising clock edge where `cs_n` and `wr_n` are both low. Address 0, 1 or 2 loads the latch of port A, B or C, and the new value is on `*_out` after that edge. With `cs_n` high, nothing changes.
- R3: A write to address 3 with bit 7 = 1 is a configuration word. The direction bits are bit 4 for port A, bit 1 for port B, bit 3 for C[7:4] and bit 0 for C[3:0], where 1 means input. A port or half that is an output has its enable bits all 1, and an input has them all 0. For example, 0x90 makes A an input and B and both halves of C outputs.
- R4: In a configuration word, bits 6:5 set `grpa_mode`: 00 gives 0, 01 gives 1, and 10 or 11 give 2, shown as 2'b10. Bit 2 sets `grpb_mode`. The value 3 never appears on `grpa_mode`.
- R5: A configuration word clears the output latches of ports A, B and C to 0x00.
- R6: A write to address 3 with bit 7 = 0 writes bit 0 into the port C latch bit selected by bits 3:1 (000 selects C0, 111 selects C7). No other latch bit changes, bits 6:4 have no effect, and the directions and group modes stay the same.
- R7: A read at a rising edge where `cs_n` and `rd_n` are both low puts a value on `rdata` after that edge. For an input port, the value is the pins. For an output port, it is the latch. Port C is chosen per half. Address 3 reads 0x00. In any cycle without a read, `rdata` is 0x00.
- R8: When a read and a write reach the same data port in the same cycle, the read returns the value from before the write, and the write still takes effect.
- R9: A write to a port that is configured as input still loads its latch, and its output enable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | 0 = port A, 1 = port B, 2 = port C, 3 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, 0 when no read |
| pa_pins_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A tri-state enable per bit |
| pb_pins_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B tri-state enable per bit |
| pc_pins_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C tri-state enable per bit |
| grpa_mode | output | 2 | Stored group A mode (0, 1, 2) |
| grpb_mode | output | 1 | Stored group B mode (0, 1) |

## Verification
A read and a write can reach the same data port in one cycle, because the bus strobes are independent levels. The bench provokes this by pulling `rd_n` and `wr_n` low together on port C. The scoreboard expects `rdata` to carry the latch value from before the edge, and a direct check confirms that `pc_out` then holds the new byte. A similar race arises between single-bit commands and directions: a bit command must leave the enables and group modes untouched even in the cycle it updates the latch.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    // Stored configuration of both port groups
    typedef struct packed {
        logic [1:0] grpa_mode;   // 0, 1 or 2
        logic       pa_in;       // 1 = port A input
        logic       pcu_in;      // 1 = port C upper half input
        logic       grpb_mode;   // 0 or 1
        logic       pb_in;       // 1 = port B input
        logic       pcl_in;      // 1 = port C lower half input
    } cfg_t;

    localparam cfg_t CFG_RESET = '{grpa_mode: 2'b00, pa_in: 1'b1, pcu_in: 1'b1,
                                   grpb_mode: 1'b0, pb_in: 1'b1, pcl_in: 1'b1};

    typedef enum logic [1:0] {
        SEL_PA  = 2'd0,
        SEL_PB  = 2'd1,
        SEL_PC  = 2'd2,
        SEL_CTL = 2'd3
    } sel_e;

    localparam int NUM_TARGETS = 4;
    localparam int NUM_PORTS   = 3;

endpackage

// File: rtl/ppio_bus_if.sv
module ppio_bus_if
    import ppio_pkg::*;
(
    input  logic                   cs_n,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic [1:0]             addr,
    output logic [NUM_TARGETS-1:0] wr_en,
    output logic                   rd_en,
    output sel_e                   rd_sel
);

    logic wr_any;

    assign wr_any = !cs_n && !wr_n;
    assign rd_en  = !cs_n && !rd_n;
    assign rd_sel = sel_e'(addr);

    for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_wr_dec
        assign wr_en[t] = wr_any && (addr == 2'(t));
    end

endmodule

// File: rtl/ppio_cfg_reg.sv
module ppio_cfg_reg
    import ppio_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg,
    output logic              cfg_load,
    output logic              bit_cmd,
    output logic [SEL_W-1:0]  bit_idx,
    output logic              bit_val
);

    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    // Top bit tells the two command kinds apart
    assign cfg_load = ctl_wr &&  wdata[DATA_W-1];
    assign bit_cmd  = ctl_wr && !wdata[DATA_W-1];
    assign bit_idx  = wdata[SEL_W:1];
    assign bit_val  = wdata[0];

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.cfg.grpa_mode = wdata[6] ? 2'b10 : {1'b0, wdata[5]};
            st_d.cfg.pa_in     = wdata[4];
            st_d.cfg.pcu_in    = wdata[3];
            st_d.cfg.grpb_mode = wdata[2];
            st_d.cfg.pb_in     = wdata[1];
            st_d.cfg.pcl_in    = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

endmodule

// File: rtl/ppio_latch.sv
module ppio_latch #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bit_en,
    input  logic [SEL_W-1:0]  bit_idx,
    input  logic              bit_val,
    output logic [DATA_W-1:0] q
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.val = '0;
        end else if (wr) begin
            st_d.val = wdata;
        end else if (bit_en) begin
            st_d.val[bit_idx] = bit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

endmodule

// File: rtl/ppio_rd_path.sv
module ppio_rd_path
    import ppio_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  sel_e              rd_sel,
    input  cfg_t              cfg,
    input  logic [DATA_W-1:0] pa_lat,
    input  logic [DATA_W-1:0] pb_lat,
    input  logic [DATA_W-1:0] pc_lat,
    input  logic [DATA_W-1:0] pa_pins,
    input  logic [DATA_W-1:0] pb_pins,
    input  logic [DATA_W-1:0] pc_pins,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } state_t;

    state_t st_d, st_q;
    logic [DATA_W-1:0] view_a, view_b, view_c;

    assign view_a = cfg.pa_in ? pa_pins : pa_lat;
    assign view_b = cfg.pb_in ? pb_pins : pb_lat;
    assign view_c = {cfg.pcu_in ? pc_pins[DATA_W-1:HALF_W] : pc_lat[DATA_W-1:HALF_W],
                     cfg.pcl_in ? pc_pins[HALF_W-1:0]      : pc_lat[HALF_W-1:0]};

    always_comb begin
        st_d      = st_q;
        st_d.data = '0;
        if (rd_en) begin
            case (rd_sel)
                SEL_PA:  st_d.data = view_a;
                SEL_PB:  st_d.data = view_b;
                SEL_PC:  st_d.data = view_c;
                default: st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.data;

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
    import ppio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_pins_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_pins_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [DATA_W-1:0] pc_pins_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe,
    output logic [1:0]        grpa_mode,
    output logic              grpb_mode
);

    localparam int SEL_W  = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;

    logic [NUM_TARGETS-1:0] wr_en;
    logic                   rd_en;
    sel_e                   rd_sel;
    cfg_t                   cfg;
    logic                   cfg_load;
    logic                   bit_cmd;
    logic [SEL_W-1:0]       bit_idx;
    logic                   bit_val;
    logic [DATA_W-1:0]      lat [NUM_PORTS];

    ppio_bus_if u_bus (
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .rd_sel (rd_sel)
    );

    ppio_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (wr_en[SEL_CTL]),
        .wdata    (wdata),
        .cfg      (cfg),
        .cfg_load (cfg_load),
        .bit_cmd  (bit_cmd),
        .bit_idx  (bit_idx),
        .bit_val  (bit_val)
    );

    // One latch per port; only port C takes single-bit commands
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lat
        ppio_latch #(.DATA_W(DATA_W)) u_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (cfg_load),
            .wr      (wr_en[p]),
            .wdata   (wdata),
            .bit_en  (bit_cmd && (p == int'(SEL_PC))),
            .bit_idx (bit_idx),
            .bit_val (bit_val),
            .q       (lat[p])
        );
    end

    ppio_rd_path #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .cfg     (cfg),
        .pa_lat  (lat[SEL_PA]),
        .pb_lat  (lat[SEL_PB]),
        .pc_lat  (lat[SEL_PC]),
        .pa_pins (pa_pins_in),
        .pb_pins (pb_pins_in),
        .pc_pins (pc_pins_in),
        .rdata   (rdata)
    );

    assign pa_out    = lat[SEL_PA];
    assign pb_out    = lat[SEL_PB];
    assign pc_out    = lat[SEL_PC];
    assign pa_oe     = {DATA_W{!cfg.pa_in}};
    assign pb_oe     = {DATA_W{!cfg.pb_in}};
    assign pc_oe     = {{HALF_W{!cfg.pcu_in}}, {HALF_W{!cfg.pcl_in}}};
    assign grpa_mode = cfg.grpa_mode;
    assign grpb_mode = cfg.grpb_mode;

endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] pa_out,
    input logic [DATA_W-1:0] pa_oe,
    input logic [DATA_W-1:0] pb_out,
    input logic [DATA_W-1:0] pb_oe,
    input logic [DATA_W-1:0] pc_out,
    input logic [DATA_W-1:0] pc_oe,
    input logic [1:0]        grpa_mode,
    input logic              grpb_mode
);

    logic ctl_wr, any_wr;
    assign any_wr = !cs_n && !wr_n;
    assign ctl_wr = any_wr && (addr == 2'd3);

    // R3: a configuration word with port A as output enables all A pins
    p_cfg_pa_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7] && !wdata[4]) |=> (pa_oe == '1));

    // R5: configuration word clears every latch
    p_cfg_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7]) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

    // R6: single-bit command keeps configuration
    p_bit_keeps_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)
                                   && $stable(grpa_mode) && $stable(grpb_mode)));

    // R6: single-bit command changes at most one port C bit
    p_bit_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7]) |=> ($countones(pc_out ^ $past(pc_out)) <= 1));

    // R7: no read gives zero read data
    p_idle_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |=> (rdata == '0));

    // R4: group A mode never shows 3
    p_grpa_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grpa_mode != 2'b11);

    // R2: without a write, directions and latches hold
    p_no_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> ($stable(pa_oe) && $stable(pc_oe) && $stable(pa_out)
                     && $stable(pb_out) && $stable(pc_out)));

endmodule

bind ppio_ctrl ppio_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .pa_out    (pa_out),
    .pa_oe     (pa_oe),
    .pb_out    (pb_out),
    .pb_oe     (pb_oe),
    .pc_out    (pc_out),
    .pc_oe     (pc_oe),
    .grpa_mode (grpa_mode),
    .grpb_mode (grpb_mode)
);

// File: tb/ppio_ctrl_tb_top.sv
module ppio_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_pins_in = 8'h00, pb_pins_in = 8'h00, pc_pins_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic [1:0] grpa_mode;
    logic       grpb_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    ppio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_pins_in(pa_pins_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_pins_in(pb_pins_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_pins_in(pc_pins_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .grpa_mode(grpa_mode), .grpb_mode(grpb_mode)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Driver: one bus cycle, pushing expected read data if reading
    task automatic bus(input logic c, input logic r, input logic w,
                       input logic [1:0] a, input logic [7:0] d,
                       input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs_n = c; rd_n = r; wr_n = w; addr = a; wdata = d;
        if (!c && !r) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus(1'b0, 1'b1, 1'b0, a, d, 8'h00, "");
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        bus(1'b0, 1'b0, 1'b1, a, 8'h00, exp, tag);
    endtask

    // Monitor: compares read data one edge after a read cycle
    always @(posedge clk) rd_seen <= rst_n && !cs_n && !rd_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R7 got=%h exp=none (unexpected read)", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog got=timeout exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pb_oe", pb_oe, 8'h00);
        check("R1 pc_oe", pc_oe, 8'h00);
        check("R1 latches", pa_out | pb_out | pc_out, 8'h00);
        check("R1 modes", {5'd0, grpa_mode, grpb_mode}, 8'h00);
        check("R1 rdata", rdata, 8'h00);

        pa_pins_in = 8'h5A; pb_pins_in = 8'hC3; pc_pins_in = 8'h96;
        rd(2'd0, 8'h5A, "R7 read A pins");
        rd(2'd2, 8'h96, "R7 read C pins");
        rd(2'd3, 8'h00, "R7 read control");

        // R3 example word
        wr(2'd3, 8'h90);
        check("R3 pa_oe 0x90", pa_oe, 8'h00);
        check("R3 pb_oe 0x90", pb_oe, 8'hFF);
        check("R3 pc_oe 0x90", pc_oe, 8'hFF);
        check("R4 modes 0x90", {5'd0, grpa_mode, grpb_mode}, 8'h00);

        wr(2'd1, 8'h3C);
        check("R2 pb_out", pb_out, 8'h3C);
        rd(2'd1, 8'h3C, "R7 read B latch");

        // R9 write to input port
        wr(2'd0, 8'h77);
        check("R9 pa_out", pa_out, 8'h77);
        check("R9 pa_oe", pa_oe, 8'h00);
        rd(2'd0, 8'h5A, "R7 read A input still pins");

        // R2 write without chip select
        bus(1'b1, 1'b1, 1'b0, 2'd1, 8'hFF, 8'h00, "");
        check("R2 cs_n high ignored", pb_out, 8'h3C);

        // R6 single-bit commands
        wr(2'd3, 8'h0B);
        check("R6 set C5", pc_out, 8'h20);
        wr(2'd3, 8'h77);
        check("R6 set C3 bits6:4 ignored", pc_out, 8'h28);
        wr(2'd3, 8'h0A);
        check("R6 clear C5", pc_out, 8'h08);
        wr(2'd3, 8'h0F);
        check("R6 set C7", pc_out, 8'h88);
        wr(2'd3, 8'h00);
        check("R6 clear C0 no-op", pc_out, 8'h88);
        check("R6 pc_oe kept", pc_oe, 8'hFF);
        check("R6 pa_oe kept", pa_oe, 8'h00);
        check("R6 modes kept", {5'd0, grpa_mode, grpb_mode}, 8'h00);
        check("R6 pb_out kept", pb_out, 8'h3C);
        rd(2'd2, 8'h88, "R7 read C latch");

        // R8 read and write same cycle
        bus(1'b0, 1'b0, 1'b0, 2'd2, 8'hF0, 8'h88, "R8 read old value");
        check("R8 write took effect", pc_out, 8'hF0);

        // R5 and R4: 0xE8 -> A mode 2, C upper input, rest outputs
        wr(2'd3, 8'hE8);
        check("R5 pa_out cleared", pa_out, 8'h00);
        check("R5 pb_out cleared", pb_out, 8'h00);
        check("R5 pc_out cleared", pc_out, 8'h00);
        check("R4 grpa 11 -> 2", {6'd0, grpa_mode}, 8'h02);
        check("R3 pc_oe halves", pc_oe, 8'h0F);
        check("R3 pa_oe out", pa_oe, 8'hFF);

        wr(2'd2, 8'hA5);
        rd(2'd2, 8'h95, "R7 read C mixed halves");
        rd(2'd0, 8'h00, "R7 read A latch after clear");

        // R4 other encodings
        wr(2'd3, 8'hA4);
        check("R4 grpa 01", {6'd0, grpa_mode}, 8'h01);
        check("R4 grpb 1", {7'd0, grpb_mode}, 8'h01);
        wr(2'd3, 8'hC3);
        check("R4 grpa 10", {6'd0, grpa_mode}, 8'h02);
        check("R4 grpb 0", {7'd0, grpb_mode}, 8'h00);
        check("R3 pb_oe input", pb_oe, 8'h00);
        check("R3 pc_oe 0xC3", pc_oe, 8'hF0);

        repeat (2) @(negedge clk);
        check("R7 queue drained", 8'(exp_q.size()), 8'h00);
        check("R7 idle rdata", rdata, 8'h00);
        finish_run();
    end

endmodule